// File: doc/BRIEF.md
# Round-Robin Shared-Bus Arbiter

This block is the central arbiter for a shared parallel bus with three requesters. Requester 0 is the chip's own initiator and requesters 1 and 2 are external masters. Each requester has an active-low request line and an active-low grant line.

The arbiter watches the bus cycle-framing signal and the initiator-ready signal. When both are deasserted (high), the bus is idle. The arbiter rotates ownership in round-robin order. While a transaction is running it hands the grant to the next master, so the next owner is chosen before the bus frees up. If nobody requests, the last grant stays in place. If the bus is idle, one whole cycle with no grant separates two different grants, which leaves time for driver turnaround. A master that holds the grant on an idle bus for 16 cycles without starting a cycle loses the grant. It then stays shut out until it releases its request for at least one clock.

When the arbiter is turned off, the internal request is passed out to an external arbiter, and that arbiter's grant is returned as the internal grant. The arbiter moves no bus data, so it has no stream interface. Every pin is a plain level that is sampled on the rising clock edge.

Top module: `busarb_rr`

## Requirements
- R1: While reset is active and right after it, only the internal grant is asserted (`gnt_n` = 3'b110, bit 0 = internal, bits 1 and 2 = external masters) and `ext_req_n` is high. At most one grant is ever low at a time.
- R2: While the bus is busy (`frame_n` or `irdy_n` low), the grant moves in a single clock to the first eligible requester found in the cyclic order 0, 1, 2, 0, starting after the most recent grantee. If only the current grantee is eligible, it keeps the grant.
- R3: While the bus is idle, a grantee that is still requesting and not locked out keeps the grant, even when other masters are requesting.
- R4: On an idle bus, if the grantee is no longer eligible and another master is, all grants go high for exactly one cycle. The next master in round-robin order is granted on the following clock. If no grant is asserted, an eligible master is granted at once.
- R5: A grantee that keeps requesting on an idle bus loses its grant on the 16th rising edge after the grant was given. All grants then go high.
- R6: The idle-cycle count restarts when the bus becomes busy or when the grant changes. It does not advance while the grantee is not requesting.
- R7: A master that has timed out gets no grant until its request has been sampled high on at least one clock edge.
- R8: When no eligible master requests, the current grant state is kept. This holds whether a grant is parked or no grant is asserted.
- R9: With `arb_en` low, `ext_req_n` follows `req_n[0]` and `gnt_n[0]` follows `ext_gnt_n`. External grants stay high and external requests are ignored. When the arbiter is enabled again, it resumes with the internal grant parked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| arb_en | input | 1 | High: internal arbiter active; low: defer to external arbiter |
| req_n | input | 3 | Active-low requests (bit 0 internal) |
| gnt_n | output | 3 | Active-low grants (bit 0 internal) |
| frame_n | input | 1 | Bus cycle framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ext_req_n | output | 1 | Internal request passed to an external arbiter |
| ext_gnt_n | input | 1 | Grant from an external arbiter for the internal initiator |

## Verification
The hardest situation to reach is the interaction of the no-start timeout with the lockout and with counter restarts. The stimulus first holds one external master requesting on an idle bus for exactly 15 edges, then for a 16th edge. It keeps the request asserted through the lockout and then drops it for a single edge. A second run places one busy cycle in the middle of a count, so the 16 edges must be counted again from that point. Parking with no request is also held for well over 16 edges, to show that the count does not advance without a request.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  // Index of the on-chip initiator among the requesters.
  localparam int HOST_IDX = 0;

  // Next-state choice of the grant register.
  typedef enum logic [2:0] {
    MOVE_OFF,
    MOVE_HOLD,
    MOVE_SWITCH,
    MOVE_DROP,
    MOVE_EXPIRE
  } move_e;
endpackage

// File: rtl/busarb_rr_pick.sv
module busarb_rr_pick #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] pick
);
  int s;

  // Walk from the farthest offset to the nearest, so the nearest eligible
  // requester after "last" is the one left in pick.
  always_comb begin
    found = 1'b0;
    pick  = last;
    s     = 0;
    for (int k = N; k >= 1; k--) begin
      s = int'(last) + k;
      if (s >= N) s = s - N;
      if (elig[s]) begin
        found = 1'b1;
        pick  = IW'(s);
      end
    end
  end
endmodule

// File: rtl/busarb_stall_timer.sv
module busarb_stall_timer #(
  parameter int LIMIT = 16,
  parameter int CW    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic restart,
  output logic expire
);
  logic [CW-1:0] cnt_q;

  assign expire = count_en && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (restart || !count_en || expire)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  // A firing timeout always leaves the count at zero for the next window.
  assert_count_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));
endmodule

// File: rtl/busarb_lockout.sv
module busarb_lockout #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] req_vec,
  output logic [N-1:0] lock_vec
);
  logic [N-1:0] lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lock_q <= '0;
    else if (flush)
      lock_q <= '0;
    else
      lock_q <= set_vec | (lock_q & req_vec);
  end

  assign lock_vec = lock_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // A lock only appears after a timeout was reported for that master.
    assert_lock_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q[i]) |-> $past(set_vec[i]));
  end
endmodule

// File: rtl/busarb_rr.sv
module busarb_rr
  import busarb_pkg::*;
#(
  parameter int MASTERS     = 3,
  parameter int STALL_LIMIT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arb_en,
  input  logic [MASTERS-1:0] req_n,
  output logic [MASTERS-1:0] gnt_n,
  input  logic               frame_n,
  input  logic               irdy_n,
  output logic               ext_req_n,
  input  logic               ext_gnt_n
);
  localparam int IW = (MASTERS > 1) ? $clog2(MASTERS) : 1;
  localparam int CW = (STALL_LIMIT > 2) ? $clog2(STALL_LIMIT) : 1;

  logic [MASTERS-1:0] req, elig, lock_q, lock_set, gnt_q, gnt_d;
  logic [IW-1:0]      last_q, last_d, pick;
  logic               found, bus_idle, cur_any, cur_elig;
  logic               stall_en, restart, expire;
  move_e              move;

  assign req      = ~req_n;
  assign bus_idle = frame_n && irdy_n;
  assign elig     = req & ~lock_q;
  assign cur_any  = |gnt_q;
  assign cur_elig = cur_any && elig[last_q];

  busarb_rr_pick #(.N(MASTERS), .IW(IW)) u_pick (
    .elig  (elig),
    .last  (last_q),
    .found (found),
    .pick  (pick)
  );

  // Count idle cycles only while the grantee is actually asking for the bus.
  assign stall_en = arb_en && cur_any && bus_idle && req[last_q];
  assign restart  = (gnt_d != gnt_q);

  busarb_stall_timer #(.LIMIT(STALL_LIMIT), .CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (stall_en),
    .restart  (restart),
    .expire   (expire)
  );

  busarb_lockout #(.N(MASTERS)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (!arb_en),
    .set_vec  (lock_set),
    .req_vec  (req),
    .lock_vec (lock_q)
  );

  always_comb begin
    if (!arb_en)        move = MOVE_OFF;
    else if (expire)    move = MOVE_EXPIRE;
    else if (!found)    move = MOVE_HOLD;
    else if (!bus_idle) move = MOVE_SWITCH;
    else if (cur_elig)  move = MOVE_HOLD;
    else if (cur_any)   move = MOVE_DROP;
    else                move = MOVE_SWITCH;
  end

  always_comb begin
    gnt_d    = gnt_q;
    last_d   = last_q;
    lock_set = '0;
    case (move)
      MOVE_OFF: begin
        gnt_d           = '0;
        gnt_d[HOST_IDX] = 1'b1;
        last_d          = IW'(HOST_IDX);
      end
      MOVE_SWITCH: begin
        gnt_d       = '0;
        gnt_d[pick] = 1'b1;
        last_d      = pick;
      end
      MOVE_DROP: gnt_d = '0;
      MOVE_EXPIRE: begin
        gnt_d            = '0;
        lock_set[last_q] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q           <= '0;
      gnt_q[HOST_IDX] <= 1'b1;
      last_q          <= IW'(HOST_IDX);
    end else begin
      gnt_q  <= gnt_d;
      last_q <= last_d;
    end
  end

  for (genvar i = 0; i < MASTERS; i++) begin : g_out
    if (i == HOST_IDX) begin : g_host
      assign gnt_n[i] = arb_en ? ~gnt_q[i] : ext_gnt_n;
    end else begin : g_ext
      assign gnt_n[i] = arb_en ? ~gnt_q[i] : 1'b1;
    end
  end

  assign ext_req_n = arb_en ? 1'b1 : req_n[HOST_IDX];

  assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~gnt_n) <= 1);

  assert_busy_handoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && !bus_idle && found) |=> (gnt_q != '0));

  assert_idle_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && bus_idle && gnt_q != '0) |=> (gnt_q == $past(gnt_q) || gnt_q == '0));

  assert_timeout_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && expire) |=> (gnt_q == '0 && lock_q[last_q]));

  assert_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && req == '0) |=> $stable(gnt_q));

  for (genvar i = 0; i < MASTERS; i++) begin : g_lock_chk
    assert_no_grant_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_en && lock_q[i]) |=> !gnt_q[i]);
  end
endmodule

// File: tb/busarb_rr_test.sv
module busarb_rr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arb_en = 1'b1;
  logic [2:0] req_n = 3'b111;
  logic [2:0] gnt_n;
  logic       frame_n = 1'b1;
  logic       irdy_n = 1'b1;
  logic       ext_req_n;
  logic       ext_gnt_n = 1'b1;

  int total = 0;
  int bad = 0;

  // Scoreboard: expected active-high grants, expected external request
  // (1 = ext_req_n low), and a tag naming the requirement.
  logic [2:0] q_g[$];
  logic       q_x[$];
  string      q_t[$];

  always #5 clk = ~clk;

  busarb_rr uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .arb_en    (arb_en),
    .req_n     (req_n),
    .gnt_n     (gnt_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .ext_req_n (ext_req_n),
    .ext_gnt_n (ext_gnt_n)
  );

  task automatic step(input logic en, input logic [2:0] r, input logic busy,
                      input logic xg_n, input logic [2:0] eg, input logic ex,
                      input string t);
    @(negedge clk);
    arb_en    = en;
    req_n     = ~r;
    frame_n   = ~busy;
    irdy_n    = 1'b1;
    ext_gnt_n = xg_n;
    q_g.push_back(eg);
    q_x.push_back(ex);
    q_t.push_back(t);
  endtask

  task automatic run(input logic [2:0] r, input logic busy,
                     input logic [2:0] eg, input string t);
    step(1'b1, r, busy, 1'b1, eg, 1'b0, t);
  endtask

  // Monitor: compare each expected item after the edge that produces it.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_g.size() > 0) begin
        logic [2:0] eg;
        logic       ex;
        string      t;
        eg = q_g.pop_front();
        ex = q_x.pop_front();
        t  = q_t.pop_front();
        total++;
        if ((~gnt_n) !== eg || ext_req_n !== ~ex) begin
          bad++;
          $display("FAIL %s: actual gnt=%b ext_req=%b expected gnt=%b ext_req=%b",
                   t, ~gnt_n, ~ext_req_n, eg, ex);
        end
      end
    end
  end

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog R1: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (gnt_n !== 3'b110 || ext_req_n !== 1'b1) begin
      bad++;
      $display("FAIL R1 reset: actual gnt_n=%b ext_req_n=%b expected gnt_n=110 ext_req_n=1",
               gnt_n, ext_req_n);
    end
    rst_n = 1'b1;

    run(3'b000, 1'b0, 3'b001, "R8 park internal after reset");
    run(3'b010, 1'b1, 3'b010, "R2 busy one-step move 0->1");
    run(3'b110, 1'b1, 3'b100, "R2 rotate 1->2");
    run(3'b111, 1'b1, 3'b001, "R2 rotate 2->0");
    run(3'b111, 1'b1, 3'b010, "R2 rotate 0->1");
    run(3'b100, 1'b0, 3'b000, "R4 idle turnaround gap");
    run(3'b100, 1'b0, 3'b100, "R4 grant after gap");
    for (int i = 0; i < 15; i++) run(3'b100, 1'b0, 3'b100, "R5 held before limit");
    run(3'b100, 1'b0, 3'b000, "R5 timeout on 16th edge");
    for (int i = 0; i < 3; i++) run(3'b100, 1'b0, 3'b000, "R7 locked while requesting");
    run(3'b000, 1'b0, 3'b000, "R7 release edge");
    run(3'b100, 1'b0, 3'b100, "R7 regrant after release");
    for (int i = 0; i < 10; i++) run(3'b100, 1'b0, 3'b100, "R6 counting");
    run(3'b100, 1'b1, 3'b100, "R6 busy cycle restarts count");
    for (int i = 0; i < 15; i++) run(3'b100, 1'b0, 3'b100, "R6 held after restart");
    run(3'b100, 1'b0, 3'b000, "R5 timeout after restart");
    run(3'b000, 1'b0, 3'b000, "R8 no request keeps empty state");
    run(3'b010, 1'b0, 3'b010, "R4 immediate grant from empty");
    run(3'b011, 1'b0, 3'b010, "R3 idle hold of current grantee");
    run(3'b011, 1'b1, 3'b001, "R2 busy rotate 1->0");
    for (int i = 0; i < 20; i++) run(3'b000, 1'b0, 3'b001, "R6 R8 parked without count");
    step(1'b0, 3'b011, 1'b0, 1'b0, 3'b001, 1'b1, "R9 external grant to internal");
    step(1'b0, 3'b110, 1'b0, 1'b1, 3'b000, 1'b0, "R9 external masters ignored");
    step(1'b0, 3'b000, 1'b0, 1'b1, 3'b000, 1'b0, "R9 no request out");
    run(3'b000, 1'b0, 3'b001, "R9 re-enable parks internal");

    repeat (3) @(posedge clk);
    #3;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule